// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller with Cascade

This block sits between eight device interrupt lines and a processor. Each line is sampled every cycle into a request register and filtered by a per-line mask. A priority resolver picks the lowest-numbered pending line. An in-service register records the levels currently being handled, so that a request interrupts only when it outranks all of them. When a request may interrupt, the block raises one interrupt output. The processor answers with a one-cycle acknowledge, and the block returns an 8-bit vector one cycle later.

A small write port loads the mask, the vector base and the cascade setting, and issues end-of-interrupt commands. One line can be declared a cascade input. It is driven by the interrupt output of a second instance of the same block. When that line wins an acknowledge, the acknowledge is passed to the second instance, and its vector is returned instead of this block's own vector.

The vector leaves as a valid pulse with no ready input. The processor must capture it in the cycle in which `vec_vld_o` is high, because it is never held back or repeated.

Top module: `irq_ctl`

## Requirements
- R1: After reset the mask has all bits set, the vector base is 0, cascade is disabled, the in-service register is empty, and `int_o` and `vec_vld_o` are low.
- R2: Request lines are level sensitive. A line held high shows as pending one clock later. A line that falls before the acknowledge leaves no in-service entry.
- R3: Writing select 0 loads the mask from `wr_data_i[7:0]`. A set bit keeps its line from being recognised.
- R4: Line 0 has the highest priority and line 7 the lowest. `int_o` is high exactly when some unmasked pending line has a lower index than every set in-service bit, or when such a line exists and nothing is in service.
- R5: Writing select 1 loads the vector base; bits [2:0] of the write are ignored. An acknowledge while `int_o` is high returns the vector {base[7:3], winning index}. In the same clock edge it clears that line's request bit and sets its in-service bit.
- R6: An acknowledge while `int_o` is low returns the vector {base[7:3], 3'b111} and leaves the in-service register unchanged.
- R7: Writing select 2 (the data is ignored) clears the highest-priority set in-service bit.
- R8: Writing select 3 sets cascade mode from `wr_data_i[0]` and the cascade line from `wr_data_i[3:1]`. When the cascade line wins an acknowledge, `casc_ack_o` is high in that same cycle, and the returned vector is `casc_vec_i` as it stands one cycle later.
- R9: Every cycle with `ack_i` high produces exactly one cycle of `vec_vld_o`, in the next cycle. `vec_vld_o` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Device request lines, active high, level sensitive |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 mask, 1 base, 2 end-of-interrupt, 3 cascade |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 1 | Processor acknowledge, one cycle per vector |
| int_o | output | 1 | Interrupt request to the processor |
| vec_vld_o | output | 1 | Vector valid pulse, no back-pressure |
| vec_o | output | 8 | Returned vector |
| casc_ack_o | output | 1 | Acknowledge forwarded to the cascaded instance |
| casc_vec_i | input | 8 | Vector from the cascaded instance |

## Verification
- A change on a request line reaches `int_o` after one clock, so the bench samples `int_o` two falling edges after it changes the lines.
- A vector is checked on the falling edge right after the rising edge that captured `ack_i`. The pulse being gone is checked one cycle after that.
- A register write takes effect at the edge that captures it, and the next check follows on a later falling edge.
- In a two-instance chain, the request passes through the second instance's request register and then through the cascade line's register. The bench therefore waits three falling edges before it checks the first instance's interrupt.
- A forwarded vector arrives in the same cycle as a local one, so the vector checks use the same sampling point.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_BASE = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_CASC = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NL = 8,
  parameter int VW = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [VW-1:0] wr_data,
  output logic [NL-1:0] mask,
  output logic [VW-IW-1:0] base_hi,
  output logic          casc_en,
  output logic [IW-1:0] casc_line,
  output logic          eoi
);
  import irq_pkg::*;

  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel);
  assign eoi = wr_en && (sel == SEL_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '1;
      base_hi   <= '0;
      casc_en   <= 1'b0;
      casc_line <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_MASK: mask <= wr_data[NL-1:0];
        SEL_BASE: base_hi <= wr_data[VW-1:IW];
        SEL_CASC: begin
          casc_en   <= wr_data[0];
          casc_line <= wr_data[IW:1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] req,
  input  logic [NL-1:0] mask,
  input  logic          ack,
  input  logic          eoi,
  output logic          irq,
  output logic          take,
  output logic [IW-1:0] win_idx,
  output logic [NL-1:0] pend,
  output logic [NL-1:0] isr
);
  logic [NL-1:0] irr;
  logic          pend_any;
  logic          isr_any;
  logic [IW-1:0] isr_idx;

  assign pend = irr & ~mask;

  irq_prio #(.N(NL)) u_pend_pri (.vec(pend), .any(pend_any), .idx(win_idx));
  irq_prio #(.N(NL)) u_isr_pri  (.vec(isr),  .any(isr_any),  .idx(isr_idx));

  assign irq  = pend_any && (!isr_any || (win_idx < isr_idx));
  assign take = ack && irq;

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic hit;
    logic done;
    assign hit  = take && (win_idx == IW'(g));
    assign done = eoi && isr_any && (isr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irr[g] <= 1'b0;
        isr[g] <= 1'b0;
      end else begin
        irr[g] <= req[g] && !hit;
        isr[g] <= (isr[g] && !done) || hit;
      end
    end
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int NL = 8,
  parameter int VW = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] req_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [VW-1:0] wr_data_i,
  input  logic          ack_i,
  output logic          int_o,
  output logic          vec_vld_o,
  output logic [VW-1:0] vec_o,
  output logic          casc_ack_o,
  input  logic [VW-1:0] casc_vec_i
);
  logic [NL-1:0]    mask;
  logic [VW-IW-1:0] base_hi;
  logic             casc_en;
  logic [IW-1:0]    casc_line;
  logic             eoi;
  logic             take;
  logic [IW-1:0]    win_idx;
  logic [NL-1:0]    pend;
  logic [NL-1:0]    isr;
  logic             casc_hit;
  logic [VW-1:0]    vec_q;
  logic             vld_q;
  logic             fwd_q;

  irq_regs #(.NL(NL), .VW(VW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
    .wr_data(wr_data_i), .mask(mask), .base_hi(base_hi),
    .casc_en(casc_en), .casc_line(casc_line), .eoi(eoi)
  );

  irq_core #(.NL(NL)) u_core (
    .clk(clk), .rst_n(rst_n), .req(req_i), .mask(mask), .ack(ack_i),
    .eoi(eoi), .irq(int_o), .take(take), .win_idx(win_idx),
    .pend(pend), .isr(isr)
  );

  assign casc_hit   = take && casc_en && (win_idx == casc_line);
  assign casc_ack_o = casc_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      vld_q <= 1'b0;
      fwd_q <= 1'b0;
    end else begin
      vld_q <= ack_i;
      if (ack_i) begin
        vec_q <= take ? {base_hi, win_idx} : {base_hi, IW'(NL - 1)};
        fwd_q <= casc_hit;
      end
    end
  end

  assign vec_vld_o = vld_q;
  assign vec_o     = fwd_q ? casc_vec_i : vec_q;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int NL = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_i,
  input logic          int_o,
  input logic          vec_vld_o,
  input logic          casc_ack_o,
  input logic          take,
  input logic          eoi,
  input logic [NL-1:0] pend,
  input logic [NL-1:0] isr
);
  a_r9_vld_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_vld_o);
  a_r9_no_vld_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_vld_o);
  a_r4_int_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (pend != '0));
  a_r5_ack_adds_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));
  a_r6_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi) |=> $stable(isr));
  a_r8_casc_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    casc_ack_o |-> (ack_i && int_o));
endmodule

bind irq_ctl irq_ctl_chk #(.NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .int_o(int_o),
  .vec_vld_o(vec_vld_o), .casc_ack_o(casc_ack_o), .take(take),
  .eoi(eoi), .pend(pend), .isr(isr)
);

// File: tb/irq_ctl_tb.sv
module irq_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] m_req = '0, s_req = '0;
  logic       m_wr = 1'b0, s_wr = 1'b0;
  logic [1:0] m_sel = '0, s_sel = '0;
  logic [7:0] m_dat = '0, s_dat = '0;
  logic       ack = 1'b0;
  logic       m_int, m_vld, m_cack, s_int, s_vld, s_cack;
  logic [7:0] m_vec, s_vec, m_req_w;
  int checks = 0, fails = 0;
  logic [7:0] e_mask, e_base, e_isr;

  always #2.5 clk = ~clk;

  assign m_req_w = m_req | {5'b0, s_int, 2'b0};

  irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(m_req_w), .wr_en_i(m_wr), .wr_sel_i(m_sel),
    .wr_data_i(m_dat), .ack_i(ack), .int_o(m_int), .vec_vld_o(m_vld),
    .vec_o(m_vec), .casc_ack_o(m_cack), .casc_vec_i(s_vec)
  );

  irq_ctl u_slave (
    .clk(clk), .rst_n(rst_n), .req_i(s_req), .wr_en_i(s_wr), .wr_sel_i(s_sel),
    .wr_data_i(s_dat), .ack_i(m_cack), .int_o(s_int), .vec_vld_o(s_vld),
    .vec_o(s_vec), .casc_ack_o(s_cack), .casc_vec_i(8'h00)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int(input logic [7:0] p, input logic [7:0] s);
    return (p != 0) && (lowest(p) < lowest(s));
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic mw(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); m_wr = 1'b1; m_sel = sel; m_dat = d;
    @(negedge clk); m_wr = 1'b0;
  endtask

  task automatic sw(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); s_wr = 1'b1; s_sel = sel; s_dat = d;
    @(negedge clk); s_wr = 1'b0;
  endtask

  task automatic do_ack(input string r, input logic [7:0] exp);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9 vld", {7'b0, m_vld}, 8'h01);
    chk(r, m_vec, exp);
    @(negedge clk);
    chk("R9 vld drop", {7'b0, m_vld}, 8'h00);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_eoi();
    mw(2'd2, 8'h00);
    if (e_isr != 0) e_isr[lowest(e_isr)] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 int", {7'b0, m_int}, 8'h00);
    chk("R1 vld", {7'b0, m_vld}, 8'h00);
    m_req = 8'h01; settle(2);
    chk("R1 mask set", {7'b0, m_int}, 8'h00);
    m_req = 8'h00;
    do_ack("R1 base zero spurious", 8'h07);

    mw(2'd0, 8'h00);
    mw(2'd1, 8'h20);
    m_req = 8'h02; settle(2);
    chk("R4 int", {7'b0, m_int}, 8'h01);
    m_req = 8'h00; settle(1);
    do_ack("R2 dropped line R6 spurious", 8'h27);
    m_req = 8'h08; settle(2);
    chk("R2 no entry left", {7'b0, m_int}, 8'h01);
    do_ack("R5 vector", 8'h23);
    settle(1);
    chk("R4 same level blocked", {7'b0, m_int}, 8'h00);
    m_req = 8'h48; settle(2);
    chk("R4 lower blocked", {7'b0, m_int}, 8'h00);
    mw(2'd0, 8'h01);
    m_req = 8'h49; settle(2);
    chk("R3 masked", {7'b0, m_int}, 8'h00);
    mw(2'd0, 8'h00); settle(1);
    chk("R4 higher preempts", {7'b0, m_int}, 8'h01);
    do_ack("R5 nested vector", 8'h20);
    m_req = 8'h08;
    mw(2'd2, 8'h00); settle(2);
    chk("R7 top cleared, level 3 still in service", {7'b0, m_int}, 8'h00);
    mw(2'd2, 8'h00); settle(1);
    chk("R7 second eoi", {7'b0, m_int}, 8'h01);
    do_ack("R5 after eoi", 8'h23);
    mw(2'd2, 8'h00);
    m_req = 8'h00;

    e_mask = 8'h00; e_base = 8'h20; e_isr = 8'h00;
    for (int it = 0; it < 400; it++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        e_mask = 8'($urandom) & 8'($urandom);
        mw(2'd0, e_mask);
      end
      if ($urandom_range(0, 9) == 0) begin
        e_base = 8'($urandom);
        mw(2'd1, e_base);
      end
      m_req = r; settle(2);
      chk("R4 random int", {7'b0, m_int}, {7'b0, exp_int(r & ~e_mask, e_isr)});
      if ($urandom_range(0, 3) != 0) begin
        if (exp_int(r & ~e_mask, e_isr)) begin
          int w;
          w = lowest(r & ~e_mask);
          do_ack("R5 random vector", {e_base[7:3], 3'(w)});
          e_isr[w] = 1'b1;
        end else begin
          do_ack("R6 random spurious", {e_base[7:3], 3'b111});
        end
      end
      if ($urandom_range(0, 2) == 0 || $countones(e_isr) > 3) model_eoi();
    end
    m_req = 8'h00;
    repeat (8) mw(2'd2, 8'h00);

    mw(2'd3, 8'h05);
    mw(2'd1, 8'h08);
    mw(2'd0, 8'hFA);
    sw(2'd1, 8'h70);
    sw(2'd0, 8'hDF);
    s_req = 8'h20; settle(3);
    chk("R8 slave raises master", {7'b0, m_int}, 8'h01);
    do_ack("R8 forwarded vector", 8'h75);
    m_req = 8'h01; settle(2);
    chk("R8 higher than cascade", {7'b0, m_int}, 8'h01);
    do_ack("R8 local vector while cascade in service", 8'h08);
    m_req = 8'h00;
    mw(2'd2, 8'h00);
    mw(2'd2, 8'h00);
    sw(2'd2, 8'h00);
    s_req = 8'h00; settle(3);
    chk("R8 idle", {7'b0, m_int}, 8'h00);
    mw(2'd3, 8'h00);
    mw(2'd0, 8'hFB);
    s_req = 8'h20; settle(3);
    chk("R8 cascade off", {7'b0, m_int}, 8'h01);
    do_ack("R8 cascade off local vector", 8'h0A);
    s_req = 8'h00;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule